// File: doc/BRIEF.md
# Logic and Reverse-Subtract Data-Processing Unit

This block is the logic-and-subtract stage of a 32-bit datapath. It receives a first operand and a second operand that an upstream shifter has already prepared, plus a 3-bit operation code. From these it produces a 32-bit result, a zero flag and a negative flag. The operation set covers bitwise AND, OR, XOR and bit-clear, a move, an inverted move, ordinary subtract and reverse subtract. With reverse subtract the shifted operand can serve as the minuend, so one pass computes forms such as `(A << 3) - A`, which is 7·A.

The arithmetic and logic are purely combinational, in separate submodules. A selector chooses between their outputs. A registered output stage with a synchronous active-high reset captures the result and both flags on each rising clock edge, so a new operand set gives a result one clock later.

Top module: `lrs_alu_top`

## Requirements
- R1: Opcode 3'b000 gives A AND B, per bit.
- R2: Opcode 3'b001 gives A OR B and opcode 3'b010 gives A XOR B, per bit.
- R3: Opcode 3'b011 (bit-clear) gives A with every bit cleared where B is 1. Bits where B is 0 pass unchanged, so 0x12345678 with B=0x0000FFFF gives 0x12340000.
- R4: Opcode 3'b100 gives B unchanged and opcode 3'b101 gives the ones' complement of B (B=0 gives 0xFFFFFFFF). With either move opcode, operand A has no effect on the result.
- R5: Opcode 3'b110 gives A − B modulo 2^32, with wraparound and no saturation.
- R6: Opcode 3'b111 gives B − A modulo 2^32. With B = A<<3 this equals 7·A modulo 2^32.
- R7: The zero flag is 1 exactly when the 32-bit result is all zeros. The negative flag equals result bit 31.
- R8: The result and flags are registered. The values for the inputs present at a rising edge appear after that edge. A synchronous active-high reset clears the result and the negative flag to 0 and sets the zero flag to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second (pre-shifted) operand |
| op_sel | input | 3 | Operation code |
| res_q | output | 32 | Registered result |
| zero_q | output | 1 | Registered zero flag |
| neg_q | output | 1 | Registered negative flag |

## Verification
Every result and flag is due exactly one rising edge after its operands and opcode are applied. The registered outputs have no other latency. The bench drives inputs on the falling edge, which places them half a cycle before the capturing edge. A reference model queue holds the expected value computed from those inputs, and the bench compares against the outputs on the next falling edge. The reset value is checked the same way, one edge after reset is asserted.

// File: rtl/lrs_alu_pkg.sv
package lrs_alu_pkg;
  parameter int unsigned DW = 32;
  parameter int unsigned OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_XOR  = 3'b010,
    OP_BCLR = 3'b011,
    OP_MOV  = 3'b100,
    OP_MVNT = 3'b101,
    OP_SUB  = 3'b110,
    OP_RSUB = 3'b111
  } alu_op_e;
endpackage

// File: rtl/lrs_logic_unit.sv
module lrs_logic_unit #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,
  input  logic         mv_sel,
  output logic [W-1:0] logic_y,
  output logic [W-1:0] move_y
);
  // per-bit logic slice, repeated across the word
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (fn)
        2'b00:   logic_y[i] = a[i] & b[i];
        2'b01:   logic_y[i] = a[i] | b[i];
        2'b10:   logic_y[i] = a[i] ^ b[i];
        default: logic_y[i] = a[i] & ~b[i];
      endcase
    end
    assign move_y[i] = mv_sel ? ~b[i] : b[i];
  end

  always_comb begin
    assert (!(fn == 2'b11) || ((logic_y & b) == '0))
      else $error("a_r3_bclr_clears");
  end
endmodule

// File: rtl/lrs_sub_unit.sv
module lrs_sub_unit #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         reverse,
  output logic [W-1:0] diff
);
  logic [W-1:0] minu, subt;
  assign minu = reverse ? b : a;
  assign subt = reverse ? a : b;
  // one adder: minuend + ~subtrahend + 1
  assign diff = minu + ~subt + {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    assert ((diff + subt) == minu) else $error("a_r5_sub_inverse");
  end
endmodule

// File: rtl/lrs_alu_top.sv
module lrs_alu_top
  import lrs_alu_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [31:0]  opnd_a,
  input  logic [31:0]  opnd_b,
  input  logic [2:0]   op_sel,
  output logic [31:0]  res_q,
  output logic         zero_q,
  output logic         neg_q
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] lg_y, mv_y, sb_y, res_d;
  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  lrs_logic_unit #(.W(W)) u_logic (
    .a(opnd_a), .b(opnd_b), .fn(op_sel[1:0]), .mv_sel(op_sel[0]),
    .logic_y(lg_y), .move_y(mv_y)
  );

  lrs_sub_unit #(.W(W)) u_sub (
    .a(opnd_a), .b(opnd_b), .reverse(op_sel[0]), .diff(sb_y)
  );

  always_comb begin
    unique case (op_sel[2:1])
      2'b10:   res_d = mv_y;
      2'b11:   res_d = sb_y;
      default: res_d = lg_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      zero_q <= 1'b1;
      neg_q  <= 1'b0;
    end else begin
      res_q  <= res_d;
      zero_q <= ~|res_d;
      neg_q  <= res_d[MSB];
    end
  end

  a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
    zero_q == (res_q == '0));
  a_r7_neg_flag: assert property (@(posedge clk) disable iff (rst)
    neg_q == res_q[MSB]);
  a_r4_move_passes_b: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MOV) |=> (res_q == $past(opnd_b)));
  a_r6_rsub_adds_back: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RSUB) |=> (res_q + $past(opnd_a) == $past(opnd_b)));
  a_r8_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (res_q == '0 && zero_q && !neg_q));
endmodule

// File: tb/lrs_alu_top_test.sv
module lrs_alu_top_test;
  logic clk = 1'b0;
  logic rst;
  logic [31:0] a, b;
  logic [2:0] op;
  logic [31:0] res;
  logic z, n;
  int checks = 0, errors = 0;
  logic [33:0] expq[$];
  string tagq[$];

  always #10 clk = ~clk;

  lrs_alu_top uut (.clk(clk), .rst(rst), .opnd_a(a), .opnd_b(b), .op_sel(op),
                   .res_q(res), .zero_q(z), .neg_q(n));

  function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    case (o)
      3'd0: return x & y;
      3'd1: return x | y;
      3'd2: return x ^ y;
      3'd3: return x & ~y;
      3'd4: return y;
      3'd5: return ~y;
      3'd6: return x - y;
      default: return y - x;
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [33:0] e);
    checks++;
    if ({res, z, n} !== e) begin
      errors++;
      $display("FAIL %s actual res=%h z=%b n=%b expected res=%h z=%b n=%b",
               tag, res, z, n, e[33:2], e[1], e[0]);
    end
  endtask

  task automatic apply(input string tag, input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] r;
    a = x; b = y; op = o;
    r = model(o, x, y);
    expq.push_back({r, r == 32'd0, r[31]});
    tagq.push_back(tag);
    @(negedge clk);
    cmp(tagq.pop_front(), expq.pop_front());
    // flag check named for R7
    checks++;
    if (z !== (res == 32'd0) || n !== res[31]) begin
      errors++;
      $display("FAIL R7 actual z=%b n=%b expected z=%b n=%b", z, n, res == 32'd0, res[31]);
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] x;
    rst = 1'b1; a = 32'hDEAD_BEEF; b = 32'h1; op = 3'd6;
    @(negedge clk); @(negedge clk);
    cmp("R8 reset", {32'd0, 1'b1, 1'b0});
    rst = 1'b0;
    apply("R1 mask", 3'd0, 32'hB6A4_3D9A, 32'h0000_0FFF);
    apply("R1 zero", 3'd0, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
    apply("R2 or", 3'd1, 32'h1234_5678, 32'h0000_FFFF);
    apply("R2 xor", 3'd2, 32'hAAAA_5555, 32'hFFFF_0000);
    apply("R3 bclr", 3'd3, 32'h1234_5678, 32'h0000_FFFF);
    apply("R3 bclr all", 3'd3, 32'h8000_0001, 32'hFFFF_FFFF);
    apply("R4 mov", 3'd4, 32'h1111_2222, 32'h8765_4321);
    apply("R4 mov A ignored", 3'd4, 32'hFFFF_FFFF, 32'h8765_4321);
    apply("R4 mvn zero", 3'd5, 32'h5A5A_5A5A, 32'h0);
    apply("R5 sub", 3'd6, 32'd100, 32'd58);
    apply("R5 sub wrap", 3'd6, 32'd0, 32'd1);
    apply("R6 rsub", 3'd7, 32'd100, 32'd58);
    apply("R6 rsub equal", 3'd7, 32'h7777_7777, 32'h7777_7777);
    x = 32'h1357_9BDF;
    apply("R6 times7", 3'd7, x, x << 3);
    checks++;
    if (res !== x * 32'd7) begin
      errors++;
      $display("FAIL R6 actual=%h expected=%h", res, x * 32'd7);
    end
    for (int i = 0; i < 200; i++)
      apply("R8 sweep", 3'(i), $urandom, (i % 5 == 0) ? 32'd0 : $urandom);
    rst = 1'b1;
    @(negedge clk);
    cmp("R8 reset again", {32'd0, 1'b1, 1'b0});
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule